// File: doc/BRIEF.md
# Coprocessor Control Register Transfer Unit

This unit stands between a host processor and a vector coprocessor. It carries out the host's two transfer instructions on the coprocessor's integer and control register file. One is a 32-bit move into a register. The other is a move out of a register that returns a 64-bit value to a host register. Each register has its own write rule. Index 0 and the three status registers that the coprocessor owns (flags, program counter, status) cannot be written. The random-seed register keeps only its 23 mantissa bits and forces the bits that encode 1.0. The reset/break control register stores only two bit pairs.

Some writes have side effects. A write to the control register sends one-cycle force-break and reset pulses to both coprocessor units. A write to the second unit's start-address register waits until that unit is idle and then sends it a start request. A request that carries the interlock bit is held until the coprocessor reports that its micro-program has ended. Requests use a valid/ready handshake. Each request gets a single-cycle response, and a second request is accepted only after that response.

Top module: `ctrl_xfer_unit`

## Requirements
- R1: After synchronous active-high reset, `req_ready` is 1 and `rsp_valid` and every pulse output are 0. Every writable register reads back zero. The seed register holds 0x3F800000, so a read of it returns 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. If nothing stalls it, `rsp_valid` is high for exactly one cycle, starting after the second rising edge counted from acceptance. `req_ready` is 1 again in that cycle.
- R3: A write to index 0 is discarded, and a read of index 0 returns 0.
- R4: Writes to index 24 (flag register), index 26 (program counter) and index 29 (status) are ignored. A read of any of these returns the matching `cp_flag_in`, `cp_pc_in` or `cp_status_in` value, sign-extended.
- R5: A write to the seed register (index 20) stores `(data & 0x7FFFFF) | 0x3F800000`. A read of it returns only the stored bits 22:0, zero-extended to 64 bits.
- R6: A read of any register other than the seed register returns its 32-bit value in bits 31:0. Bits 63:32 are all ones when bit 31 is 1 and zero otherwise.
- R7: A write to the control register (index 28) stores `data & 0x0C0C`.
- R8: In a write to index 28, data bit 0 drives `u0_brk`, bit 1 drives `u0_rst`, bit 8 drives `u1_brk` and bit 9 drives `u1_rst`. Each pulse lasts one cycle and is high together with `rsp_valid`. No other request drives these outputs.
- R9: A write to index 31 is stored unchanged. It completes only after a rising edge where `u1_busy` is 0. It then raises `u1_start` for one cycle, together with `rsp_valid`, and `u1_start_addr` equals data bits 15:0.
- R10: A request with `req_interlock` set completes only after a rising edge where `cp_busy` is 0. No response, pulse or register update happens before that edge.
- R11: A read with `req_dst_zero` set still responds, but `rsp_wen` is 0 and `rsp_rdata` is 0. A normal read raises `rsp_wen` together with `rsp_valid`. A write never raises `rsp_wen`.
- R12: A write to any other index stores all 32 data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = move into register, 0 = move out |
| req_idx | input | 5 | Register index |
| req_wdata | input | 32 | Write data |
| req_interlock | input | 1 | Hold until the coprocessor micro-program has ended |
| req_dst_zero | input | 1 | Host destination of a read is register 0 |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_wen | output | 1 | Host register update enable for a read |
| rsp_rdata | output | 64 | Formatted read data |
| cp_busy | input | 1 | Coprocessor micro-program running |
| u1_busy | input | 1 | Second unit running |
| cp_flag_in | input | 32 | Live flag register value |
| cp_pc_in | input | 32 | Live program counter value |
| cp_status_in | input | 32 | Live status value |
| u0_brk | output | 1 | Force-break pulse, unit 0 |
| u0_rst | output | 1 | Reset pulse, unit 0 |
| u1_brk | output | 1 | Force-break pulse, unit 1 |
| u1_rst | output | 1 | Reset pulse, unit 1 |
| u1_start | output | 1 | Start request pulse, unit 1 |
| u1_start_addr | output | 16 | Start address for unit 1 |

## Verification
The interlock wait and the wait for the second unit to go idle can hold the same request at the same time. This happens for a start-address write that also carries the interlock bit. The bench raises `cp_busy` and `u1_busy` together and then lowers them one at a time, once in each order. It checks that neither `rsp_valid` nor `u1_start` appears while either input is still high. It then checks that both appear, with the right address, exactly one cycle after the last one falls.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

   typedef enum logic [2:0] {
      SLOT_ZERO,
      SLOT_PLAIN,
      SLOT_RO,
      SLOT_SEED,
      SLOT_CTRL,
      SLOT_START
   } slot_kind_e;

   typedef enum logic {
      ST_IDLE,
      ST_HOLD
   } seq_state_e;

   // Classify a register index by its write rule.
   function automatic slot_kind_e slot_kind(input int idx, input int flag_i,
                                            input int pc_i, input int stat_i,
                                            input int seed_i, input int ctrl_i,
                                            input int start_i);
      if (idx == 0)                                          return SLOT_ZERO;
      if (idx == flag_i || idx == pc_i || idx == stat_i)     return SLOT_RO;
      if (idx == seed_i)                                     return SLOT_SEED;
      if (idx == ctrl_i)                                     return SLOT_CTRL;
      if (idx == start_i)                                    return SLOT_START;
      return SLOT_PLAIN;
   endfunction

endpackage

// File: rtl/cxu_slot.sv
module cxu_slot #(
   parameter int            DW        = 32,
   parameter logic [DW-1:0] KEEP_MASK = '1,
   parameter logic [DW-1:0] FORCE_VAL = '0,
   parameter logic [DW-1:0] RST_VAL   = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_VAL;
      end else if (we) begin
         q <= (wdata & KEEP_MASK) | FORCE_VAL;
      end
   end

endmodule

// File: rtl/cxu_rdfmt.sv
module cxu_rdfmt #(
   parameter int DW     = 32,
   parameter int KEEP_W = 23
) (
   input  logic [DW-1:0]   val,
   input  logic            masked,
   output logic [2*DW-1:0] dout
);

   always_comb begin
      if (masked) begin
         dout = {{(2*DW-KEEP_W){1'b0}}, val[KEEP_W-1:0]};
      end else begin
         dout = {{DW{val[DW-1]}}, val};
      end
   end

endmodule

// File: rtl/cxu_seq.sv
module cxu_seq #(
   parameter int IDX_W     = 5,
   parameter int DW        = 32,
   parameter int IDX_START = 31
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [DW-1:0]    req_wdata,
   input  logic             req_interlock,
   input  logic             req_dst_zero,
   input  logic             cp_busy,
   input  logic             u1_busy,
   output logic             commit,
   output logic             cur_write,
   output logic [IDX_W-1:0] cur_idx,
   output logic [DW-1:0]    cur_wdata,
   output logic             cur_dstz
);
   import cxu_pkg::*;

   localparam logic [IDX_W-1:0] START_I = IDX_W'(IDX_START);

   seq_state_e state;
   logic       cur_il;
   logic       wait_il;
   logic       wait_u1;

   assign req_ready = (state == ST_IDLE);
   assign wait_il   = cur_il & cp_busy;
   assign wait_u1   = cur_write & (cur_idx == START_I) & u1_busy;
   assign commit    = (state == ST_HOLD) & ~wait_il & ~wait_u1;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         cur_write <= 1'b0;
         cur_idx   <= '0;
         cur_wdata <= '0;
         cur_dstz  <= 1'b0;
         cur_il    <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state     <= ST_HOLD;
                  cur_write <= req_write;
                  cur_idx   <= req_idx;
                  cur_wdata <= req_wdata;
                  cur_dstz  <= req_dst_zero;
                  cur_il    <= req_interlock;
               end
            end
            default: begin
               if (commit) state <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/ctrl_xfer_unit.sv
module ctrl_xfer_unit #(
   parameter int            NREG        = 32,
   parameter int            DW          = 32,
   parameter int            ADDR_W      = 16,
   parameter int            IDX_SEED    = 20,
   parameter int            IDX_FLAG    = 24,
   parameter int            IDX_PC      = 26,
   parameter int            IDX_CTRL    = 28,
   parameter int            IDX_STATUS  = 29,
   parameter int            IDX_START   = 31,
   parameter int            SEED_KEEP_W = 23,
   parameter logic [DW-1:0] SEED_FORCE  = 32'h3F80_0000,
   parameter logic [DW-1:0] CTRL_MASK   = 32'h0000_0C0C,
   parameter int            BIT_BRK0    = 0,
   parameter int            BIT_RST0    = 1,
   parameter int            BIT_BRK1    = 8,
   parameter int            BIT_RST1    = 9,
   localparam int           IDX_W       = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [DW-1:0]     req_wdata,
   input  logic              req_interlock,
   input  logic              req_dst_zero,
   output logic              rsp_valid,
   output logic              rsp_wen,
   output logic [2*DW-1:0]   rsp_rdata,
   input  logic              cp_busy,
   input  logic              u1_busy,
   input  logic [DW-1:0]     cp_flag_in,
   input  logic [DW-1:0]     cp_pc_in,
   input  logic [DW-1:0]     cp_status_in,
   output logic              u0_brk,
   output logic              u0_rst,
   output logic              u1_brk,
   output logic              u1_rst,
   output logic              u1_start,
   output logic [ADDR_W-1:0] u1_start_addr
);
   import cxu_pkg::*;

   localparam logic [DW-1:0]    SEED_KEEP = DW'((64'd1 << SEED_KEEP_W) - 64'd1);
   localparam logic [IDX_W-1:0] CTRL_I    = IDX_W'(IDX_CTRL);
   localparam logic [IDX_W-1:0] START_I   = IDX_W'(IDX_START);
   localparam logic [IDX_W-1:0] SEED_I    = IDX_W'(IDX_SEED);

   // Elaboration-time parameter checks
   if (NREG != (1 << IDX_W)) begin : g_bad_nreg
      initial $fatal(1, "NREG must be a power of two");
   end
   if (SEED_KEEP_W >= DW || ADDR_W > DW) begin : g_bad_width
      initial $fatal(1, "field widths exceed the data width");
   end
   if (BIT_RST1 >= DW || BIT_BRK1 >= DW || BIT_RST0 >= DW || BIT_BRK0 >= DW) begin : g_bad_bits
      initial $fatal(1, "control bit position outside the data word");
   end
   if (IDX_START >= NREG || IDX_CTRL >= NREG || IDX_SEED >= NREG ||
       IDX_FLAG >= NREG || IDX_PC >= NREG || IDX_STATUS >= NREG) begin : g_bad_idx
      initial $fatal(1, "special register index outside the register file");
   end

   logic             commit;
   logic             cur_write;
   logic [IDX_W-1:0] cur_idx;
   logic [DW-1:0]    cur_wdata;
   logic             cur_dstz;

   cxu_seq #(.IDX_W(IDX_W), .DW(DW), .IDX_START(IDX_START)) u_seq (
      .clk          (clk),
      .rst          (rst),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_write    (req_write),
      .req_idx      (req_idx),
      .req_wdata    (req_wdata),
      .req_interlock(req_interlock),
      .req_dst_zero (req_dst_zero),
      .cp_busy      (cp_busy),
      .u1_busy      (u1_busy),
      .commit       (commit),
      .cur_write    (cur_write),
      .cur_idx      (cur_idx),
      .cur_wdata    (cur_wdata),
      .cur_dstz     (cur_dstz)
   );

   logic [NREG-1:0][DW-1:0] slot_q;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      localparam slot_kind_e KIND = slot_kind(i, IDX_FLAG, IDX_PC, IDX_STATUS,
                                              IDX_SEED, IDX_CTRL, IDX_START);
      if (KIND == SLOT_ZERO) begin : g_zero
         assign slot_q[i] = '0;
      end else if (KIND == SLOT_RO) begin : g_ro
         if (i == IDX_FLAG) begin : g_flag
            assign slot_q[i] = cp_flag_in;
         end else if (i == IDX_PC) begin : g_pc
            assign slot_q[i] = cp_pc_in;
         end else begin : g_stat
            assign slot_q[i] = cp_status_in;
         end
      end else begin : g_store
         localparam logic [DW-1:0] KEEP  = (KIND == SLOT_SEED) ? SEED_KEEP :
                                           (KIND == SLOT_CTRL) ? CTRL_MASK : '1;
         localparam logic [DW-1:0] FORCE = (KIND == SLOT_SEED) ? SEED_FORCE : '0;
         localparam logic [DW-1:0] RSTV  = (KIND == SLOT_SEED) ? SEED_FORCE : '0;
         logic we;
         assign we = commit & cur_write & (cur_idx == IDX_W'(i));
         cxu_slot #(.DW(DW), .KEEP_MASK(KEEP), .FORCE_VAL(FORCE), .RST_VAL(RSTV)) u_reg (
            .clk  (clk),
            .rst  (rst),
            .we   (we),
            .wdata(cur_wdata),
            .q    (slot_q[i])
         );
      end
   end

   logic [2*DW-1:0] fmt_data;

   cxu_rdfmt #(.DW(DW), .KEEP_W(SEED_KEEP_W)) u_fmt (
      .val   (slot_q[cur_idx]),
      .masked(cur_idx == SEED_I),
      .dout  (fmt_data)
   );

   logic wr_ctrl;
   logic wr_start;
   logic rd_live;

   assign wr_ctrl  = commit & cur_write & (cur_idx == CTRL_I);
   assign wr_start = commit & cur_write & (cur_idx == START_I);
   assign rd_live  = ~cur_write & ~cur_dstz;

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid     <= 1'b0;
         rsp_wen       <= 1'b0;
         rsp_rdata     <= '0;
         u0_brk        <= 1'b0;
         u0_rst        <= 1'b0;
         u1_brk        <= 1'b0;
         u1_rst        <= 1'b0;
         u1_start      <= 1'b0;
         u1_start_addr <= '0;
      end else begin
         rsp_valid <= commit;
         rsp_wen   <= commit & rd_live;
         if (commit) rsp_rdata <= rd_live ? fmt_data : '0;
         u0_brk    <= wr_ctrl & cur_wdata[BIT_BRK0];
         u0_rst    <= wr_ctrl & cur_wdata[BIT_RST0];
         u1_brk    <= wr_ctrl & cur_wdata[BIT_BRK1];
         u1_rst    <= wr_ctrl & cur_wdata[BIT_RST1];
         u1_start  <= wr_start;
         if (wr_start) u1_start_addr <= cur_wdata[ADDR_W-1:0];
      end
   end

endmodule

// File: rtl/cxu_chk.sv
module cxu_chk #(
   parameter int IDX_W    = 5,
   parameter int DW       = 32,
   parameter int KEEP_W   = 23,
   parameter int IDX_SEED = 20,
   parameter int IDX_CTRL = 28
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_write,
   input logic [IDX_W-1:0] req_idx,
   input logic             req_interlock,
   input logic             rsp_valid,
   input logic             rsp_wen,
   input logic [2*DW-1:0]  rsp_rdata,
   input logic             cp_busy,
   input logic             u1_busy,
   input logic             u0_brk,
   input logic             u0_rst,
   input logic             u1_brk,
   input logic             u1_rst,
   input logic             u1_start
);
   logic             cap_write;
   logic             cap_il;
   logic [IDX_W-1:0] cap_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_write <= 1'b0;
         cap_il    <= 1'b0;
         cap_idx   <= '0;
      end else if (req_valid && req_ready) begin
         cap_write <= req_write;
         cap_il    <= req_interlock;
         cap_idx   <= req_idx;
      end
   end

   // R2
   single_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |=> !rsp_valid);

   // R2
   ready_on_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> req_ready);

   // R10
   interlock_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && cap_il) |-> !$past(cp_busy));

   // R9
   start_wait_chk: assert property (@(posedge clk) disable iff (rst)
      u1_start |-> (rsp_valid && !$past(u1_busy)));

   // R8
   pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
      (u0_brk || u0_rst || u1_brk || u1_rst) |->
         (rsp_valid && cap_write && cap_idx == IDX_W'(IDX_CTRL)));

   // R5
   seed_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !cap_write && cap_idx == IDX_W'(IDX_SEED)) |->
         (rsp_rdata[2*DW-1:KEEP_W] == '0));

   // R6
   sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !cap_write && cap_idx != IDX_W'(IDX_SEED)) |->
         (rsp_rdata[2*DW-1:DW] == {DW{rsp_rdata[DW-1]}}));

   // R11
   wen_read_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_wen |-> (rsp_valid && !cap_write));

endmodule

bind ctrl_xfer_unit cxu_chk #(
   .IDX_W   (IDX_W),
   .DW      (DW),
   .KEEP_W  (SEED_KEEP_W),
   .IDX_SEED(IDX_SEED),
   .IDX_CTRL(IDX_CTRL)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_write    (req_write),
   .req_idx      (req_idx),
   .req_interlock(req_interlock),
   .rsp_valid    (rsp_valid),
   .rsp_wen      (rsp_wen),
   .rsp_rdata    (rsp_rdata),
   .cp_busy      (cp_busy),
   .u1_busy      (u1_busy),
   .u0_brk       (u0_brk),
   .u0_rst       (u0_rst),
   .u1_brk       (u1_brk),
   .u1_rst       (u1_rst),
   .u1_start     (u1_start)
);

// File: tb/ctrl_xfer_unit_test.sv
module ctrl_xfer_unit_test;

   localparam logic [31:0] FLAG_V = 32'h8000_1234;
   localparam logic [31:0] PC_V   = 32'h0000_0ABC;
   localparam logic [31:0] STAT_V = 32'hF000_0001;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic        req_write;
   logic [4:0]  req_idx;
   logic [31:0] req_wdata;
   logic        req_interlock;
   logic        req_dst_zero;
   logic        rsp_valid;
   logic        rsp_wen;
   logic [63:0] rsp_rdata;
   logic        cp_busy;
   logic        u1_busy;
   logic [31:0] cp_flag_in;
   logic [31:0] cp_pc_in;
   logic [31:0] cp_status_in;
   logic        u0_brk;
   logic        u0_rst;
   logic        u1_brk;
   logic        u1_rst;
   logic        u1_start;
   logic [15:0] u1_start_addr;

   always #2 clk = ~clk;

   ctrl_xfer_unit uut (.*);

   int          n_chk  = 0;
   int          n_fail = 0;
   logic [31:0] mdl [32];

   logic [63:0] g_rdata;
   logic        g_wen;
   logic [3:0]  g_pulse;
   logic        g_start;
   logic [15:0] g_addr;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void mdl_write(input int idx, input logic [31:0] d);
      case (idx)
         0, 24, 26, 29: ;
         20:      mdl[idx] = (d & 32'h007F_FFFF) | 32'h3F80_0000;
         28:      mdl[idx] = d & 32'h0000_0C0C;
         default: mdl[idx] = d;
      endcase
   endfunction

   function automatic logic [63:0] exp_rd(input int idx);
      logic [31:0] v;
      if (idx == 20) return {41'd0, mdl[20][22:0]};
      case (idx)
         24:      v = FLAG_V;
         26:      v = PC_V;
         29:      v = STAT_V;
         default: v = mdl[idx];
      endcase
      return {{32{v[31]}}, v};
   endfunction

   function automatic string tag_of(input int idx);
      if (idx == 0) return "R3 index zero";
      if (idx == 24 || idx == 26 || idx == 29) return "R4 read-only";
      if (idx == 20) return "R5 seed";
      if (idx == 28) return "R7 control";
      if (idx == 31) return "R9 start";
      return "R12 plain";
   endfunction

   // Issue one request at a negedge and wait for its response.
   task automatic xfer(input bit wr, input int idx, input logic [31:0] d,
                       input bit il, input bit dz);
      int lat;
      req_valid     = 1'b1;
      req_write     = wr;
      req_idx       = 5'(idx);
      req_wdata     = d;
      req_interlock = il;
      req_dst_zero  = dz;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      while (!rsp_valid && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == 1, "R2 latency", 64'(lat), 64'd1);
      g_rdata = rsp_rdata;
      g_wen   = rsp_wen;
      g_pulse = {u1_rst, u1_brk, u0_rst, u0_brk};
      g_start = u1_start;
      g_addr  = u1_start_addr;
      @(negedge clk);
      chk(!rsp_valid && req_ready && ({u1_rst, u1_brk, u0_rst, u0_brk} == 4'd0),
          "R2 one-cycle response", {rsp_valid, req_ready, u1_rst, u1_brk, u0_rst, u0_brk},
          6'b010000);
   endtask

   task automatic rd_do(input int idx, input bit dz);
      logic [63:0] e;
      xfer(1'b0, idx, $urandom, 1'b0, dz);
      e = dz ? 64'd0 : exp_rd(idx);
      chk(g_rdata == e, dz ? "R11 discarded read data" : tag_of(idx), g_rdata, e);
      chk(g_wen == !dz, "R11 write enable", 64'(g_wen), 64'(!dz));
   endtask

   task automatic wr_do(input int idx, input logic [31:0] d, input bit il);
      logic [3:0] ep;
      xfer(1'b1, idx, d, il, 1'b0);
      ep = (idx == 28) ? {d[9], d[8], d[1], d[0]} : 4'd0;
      chk(g_pulse == ep, "R8 pulses", 64'(g_pulse), 64'(ep));
      chk(g_start == (idx == 31), "R9 start pulse", 64'(g_start), 64'(idx == 31));
      if (idx == 31) chk(g_addr == d[15:0], "R9 start address", 64'(g_addr), 64'(d[15:0]));
      chk(g_wen == 1'b0, "R11 no enable on write", 64'(g_wen), 64'd0);
      mdl_write(idx, d);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
      mdl[20] = 32'h3F80_0000;
      rst = 1'b1;
      req_valid = 1'b0; req_write = 1'b0; req_idx = '0; req_wdata = '0;
      req_interlock = 1'b0; req_dst_zero = 1'b0;
      cp_busy = 1'b0; u1_busy = 1'b0;
      cp_flag_in = FLAG_V; cp_pc_in = PC_V; cp_status_in = STAT_V;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk(req_ready && !rsp_valid && !u1_start && !u0_brk && !u0_rst && !u1_brk && !u1_rst,
          "R1 reset outputs", {req_ready, rsp_valid, u1_start}, 3'b100);
      rd_do(20, 1'b0);
      chk(g_rdata == 64'd0, "R1 seed reset read", g_rdata, 64'd0);
      rd_do(5, 1'b0);
      rd_do(28, 1'b0);

      // R3
      wr_do(0, 32'hFFFF_FFFF, 1'b0);
      rd_do(0, 1'b0);

      // R4
      wr_do(24, 32'h1111_1111, 1'b0);
      wr_do(26, 32'h2222_2222, 1'b0);
      wr_do(29, 32'h3333_3333, 1'b0);
      rd_do(24, 1'b0);
      rd_do(26, 1'b0);
      rd_do(29, 1'b0);

      // R5
      wr_do(20, 32'hFFFF_FFFF, 1'b0);
      rd_do(20, 1'b0);
      chk(g_rdata == 64'h7F_FFFF, "R5 seed mask", g_rdata, 64'h7F_FFFF);
      wr_do(20, 32'h0000_0000, 1'b0);
      rd_do(20, 1'b0);

      // R6, R12
      wr_do(7, 32'h8000_0001, 1'b0);
      rd_do(7, 1'b0);
      chk(g_rdata == 64'hFFFF_FFFF_8000_0001, "R6 negative extend", g_rdata,
          64'hFFFF_FFFF_8000_0001);
      wr_do(7, 32'h7FFF_FFFF, 1'b0);
      rd_do(7, 1'b0);

      // R7, R8
      wr_do(28, 32'h0000_FFFF, 1'b0);
      rd_do(28, 1'b0);
      chk(g_rdata == 64'h0C0C, "R7 control mask", g_rdata, 64'h0C0C);
      wr_do(28, 32'h0000_0102, 1'b0);

      // R11
      wr_do(9, 32'hDEAD_BEEF, 1'b0);
      rd_do(9, 1'b1);

      // R9, R10: both waits overlap, cp_busy released first
      cp_busy = 1'b1; u1_busy = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_idx = 5'd31;
      req_wdata = 32'h0001_BEEF; req_interlock = 1'b1; req_dst_zero = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(!rsp_valid && !u1_start, "R10 held by interlock", {rsp_valid, u1_start}, 2'b00);
      end
      cp_busy = 1'b0;
      @(negedge clk);
      chk(!rsp_valid && !u1_start, "R9 held by busy unit", {rsp_valid, u1_start}, 2'b00);
      u1_busy = 1'b0;
      @(negedge clk);
      chk(rsp_valid && u1_start, "R9 start after idle", {rsp_valid, u1_start}, 2'b11);
      chk(u1_start_addr == 16'hBEEF, "R9 start address", 64'(u1_start_addr), 64'hBEEF);
      mdl_write(31, 32'h0001_BEEF);
      @(negedge clk);

      // Overlap again, u1_busy released first
      cp_busy = 1'b1; u1_busy = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_idx = 5'd31;
      req_wdata = 32'hA5A5_0042; req_interlock = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      u1_busy = 1'b0;
      @(negedge clk);
      chk(!rsp_valid && !u1_start, "R10 held after unit idle", {rsp_valid, u1_start}, 2'b00);
      cp_busy = 1'b0;
      @(negedge clk);
      chk(rsp_valid && u1_start && u1_start_addr == 16'h0042, "R9 start after interlock",
          {rsp_valid, u1_start, u1_start_addr}, {2'b11, 16'h0042});
      mdl_write(31, 32'hA5A5_0042);
      @(negedge clk);
      rd_do(31, 1'b0);

      // R10: interlocked read sees no register update before release
      cp_busy = 1'b1;
      req_valid = 1'b1; req_write = 1'b0; req_idx = 5'd7; req_interlock = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(!rsp_valid && !rsp_wen, "R10 read held", {rsp_valid, rsp_wen}, 2'b00);
      cp_busy = 1'b0;
      @(negedge clk);
      chk(rsp_valid && rsp_wen && rsp_rdata == exp_rd(7), "R10 read after release",
          rsp_rdata, exp_rd(7));
      @(negedge clk);

      // Random mix
      for (int n = 0; n < 300; n++) begin
         int idx;
         idx = int'($urandom_range(31, 0));
         if ($urandom_range(1, 0) == 1) wr_do(idx, $urandom, 1'($urandom_range(1, 0)));
         else rd_do(idx, $urandom_range(7, 0) == 0);
      end

      summary();
      $finish;
   end

endmodule